// File: doc/BRIEF.md
# Pulse-Pause Receive Bit Decoder

This block recovers bits and frames from the envelope of a reader-to-card link that uses pulse-pause modulation. The input is a single synchronized envelope level plus a timebase tick enable. The block times each interval between rising edges of the envelope in ticks. A long interval is a one, a short interval is a zero, and any other interval is rejected.

Decoded bits are packed into a frame register. A frame ends when a rising edge arrives with an interval that fits neither bit class, or when no edge arrives within the longest legal bit time. A frame that ends with enough bits is presented for one clock cycle together with its bit count. A shorter frame is dropped without any indication. The block does not interpret the frame contents. Envelope detection and input synchronization are done upstream.

Top module: `pulse_pause_rx`

## Requirements
- R1: A rising edge of `env_i` restarts the interval count. The count advances only in cycles where `tick_i` is high, so one interval measures the number of ticks between two consecutive rising edges.
- R2: An interval strictly greater than 100 and strictly less than 140 ticks (nominal 120 ± 20, bounds excluded) decodes as bit value 1.
- R3: An interval strictly greater than 40 and strictly less than 80 ticks (nominal 60 ± 20, bounds excluded) decodes as bit value 0.
- R4: The first decoded bit of a frame goes to bit 0 of `frame_data_o`, and each later bit goes one position higher. After 32 bits, further bits are dropped and the count stays at 32.
- R5: While a frame is open, a rising edge whose interval fits neither class closes the frame in that cycle. That edge restarts the interval count, so the next valid interval opens a new frame.
- R6: While a frame is open and no rising edge arrives, the frame closes when the count reaches 140 ticks.
- R7: A closed frame with 4 or fewer bits is discarded and produces no strobe. A frame with 5 or more bits is delivered.
- R8: `frame_valid_o` is high for exactly one cycle per delivered frame, and `frame_data_o` and `frame_bits_o` carry that frame during that cycle. In every other cycle, all three outputs are zero.
- R9: With no rising edge, the interval count stops and holds at 2400 ticks (20 nominal one-bit times). A rising edge that follows such an idle gap is not decoded as a bit.
- R10: While `rst_ni` is low, all outputs are zero and no frame is open. The first rising edge after reset only starts timing and produces no bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| env_i | input | 1 | Synchronized envelope level |
| tick_i | input | 1 | Timebase enable; one tick per high cycle |
| frame_valid_o | output | 1 | One-cycle strobe for a delivered frame |
| frame_data_o | output | 32 | Frame bits, first received bit in bit 0 |
| frame_bits_o | output | 6 | Number of bits in the delivered frame |

## Verification
Mixed one/zero frames show that the two bit classes are told apart and that bits are packed with the first bit at position 0. Intervals placed one tick inside and one tick outside each tolerance window check that accepted intervals decode as bits and rejected ones close the frame at once, not after the timeout. A frame split by an unmatched edge checks that the frame closes and a new one starts. Frames of four and of five bits locate the runt threshold. A 34-bit frame checks the saturation at 32 bits. A run with half-rate ticks and doubled intervals checks that decoding counts ticks, not clocks. An idle gap far longer than the hold limit checks that the following edge starts a fresh frame.

// File: rtl/ppd_pkg.sv
package ppd_pkg;
  typedef enum logic [1:0] {
    SYM_NONE = 2'd0,
    SYM_ZERO = 2'd1,
    SYM_ONE  = 2'd2,
    SYM_BAD  = 2'd3
  } sym_e;
endpackage

// File: rtl/ppd_interval_timer.sv
module ppd_interval_timer #(
  parameter int CNT_W      = 12,
  parameter int IDLE_TICKS = 2400
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             env_i,
  input  logic             tick_i,
  output logic             rise_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(IDLE_TICKS);

  logic env_q;
  logic running_q;

  assign rise_o = env_i & ~env_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      env_q     <= 1'b0;
      running_q <= 1'b0;
      cnt_o     <= '0;
    end else begin
      env_q <= env_i;
      if (rise_o) begin
        // the tick of the restart cycle already belongs to the new interval
        cnt_o     <= CNT_W'(tick_i);
        running_q <= 1'b1;
      end else if (running_q && tick_i) begin
        if (cnt_o >= CNT_CAP) running_q <= 1'b0;
        else                  cnt_o     <= cnt_o + 1'b1;
      end
    end
  end

  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> (cnt_o <= CNT_W'(1))); // R1
  AST_TICK_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !rise_o) |=> $stable(cnt_o)); // R1
  AST_IDLE_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CNT_CAP); // R9
endmodule

// File: rtl/ppd_classifier.sv
module ppd_classifier
  import ppd_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int ONE_TICKS  = 120,
  parameter int ZERO_TICKS = 60,
  parameter int TOL_TICKS  = 20
) (
  input  logic [CNT_W-1:0] cnt_i,
  output sym_e             sym_o
);
  localparam logic [CNT_W-1:0] ONE_LO  = CNT_W'(ONE_TICKS - TOL_TICKS);
  localparam logic [CNT_W-1:0] ONE_HI  = CNT_W'(ONE_TICKS + TOL_TICKS);
  localparam logic [CNT_W-1:0] ZERO_LO = CNT_W'(ZERO_TICKS - TOL_TICKS);
  localparam logic [CNT_W-1:0] ZERO_HI = CNT_W'(ZERO_TICKS + TOL_TICKS);

  logic is_one, is_zero;

  // window bounds are exclusive
  assign is_one  = (cnt_i > ONE_LO)  && (cnt_i < ONE_HI);
  assign is_zero = (cnt_i > ZERO_LO) && (cnt_i < ZERO_HI);

  always_comb begin
    if (is_one)       sym_o = SYM_ONE;
    else if (is_zero) sym_o = SYM_ZERO;
    else              sym_o = SYM_BAD;
  end

  always_comb begin
    assert (!(is_one && is_zero)); // R2 R3 windows disjoint
  end
endmodule

// File: rtl/ppd_frame_asm.sv
module ppd_frame_asm
  import ppd_pkg::*;
#(
  parameter int FRAME_W  = 32,
  parameter int MIN_BITS = 5,
  parameter int BITS_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rise_i,
  input  sym_e               sym_i,
  input  logic               timeout_i,
  output logic               valid_o,
  output logic [FRAME_W-1:0] data_o,
  output logic [BITS_W-1:0]  bits_o
);
  localparam logic [BITS_W-1:0] FULL = BITS_W'(FRAME_W);
  localparam logic [BITS_W-1:0] KEEP = BITS_W'(MIN_BITS);

  logic               active_q;
  logic [FRAME_W-1:0] acc_q;
  logic [BITS_W-1:0]  nbits_q;
  logic               bit_ok, end_frame, bit_val;

  assign bit_ok    = rise_i && (sym_i == SYM_ONE || sym_i == SYM_ZERO);
  assign bit_val   = (sym_i == SYM_ONE);
  assign end_frame = active_q && ((rise_i && !bit_ok) || timeout_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      nbits_q  <= '0;
      valid_o  <= 1'b0;
      data_o   <= '0;
      bits_o   <= '0;
    end else begin
      valid_o <= 1'b0;
      data_o  <= '0;
      bits_o  <= '0;
      if (end_frame) begin
        active_q <= 1'b0;
        nbits_q  <= '0;
        if (nbits_q >= KEEP) begin
          valid_o <= 1'b1;
          data_o  <= acc_q;
          bits_o  <= nbits_q;
        end
      end else if (bit_ok) begin
        active_q <= 1'b1;
        if (nbits_q < FULL) nbits_q <= nbits_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < FRAME_W; g++) begin : g_acc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      acc_q[g] <= 1'b0;
      else if (end_frame)                               acc_q[g] <= 1'b0;
      else if (bit_ok && nbits_q == BITS_W'(g))         acc_q[g] <= bit_val;
    end
  end

  AST_STROBE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R8
  AST_QUIET_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (data_o == '0 && bits_o == '0)); // R8
  AST_NO_RUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (bits_o >= KEEP)); // R7
  AST_BITS_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nbits_q <= FULL); // R4
  AST_BAD_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && sym_i == SYM_BAD) |=> !active_q); // R5
  AST_TIMEOUT_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_i && !rise_i) |=> !active_q); // R6
endmodule

// File: rtl/pulse_pause_rx.sv
module pulse_pause_rx
  import ppd_pkg::*;
#(
  parameter int ONE_TICKS  = 120,
  parameter int ZERO_TICKS = 60,
  parameter int TOL_TICKS  = 20,
  parameter int IDLE_BITS  = 20,
  parameter int FRAME_W    = 32,
  parameter int MIN_BITS   = 5,
  localparam int BITS_W    = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               env_i,
  input  logic               tick_i,
  output logic               frame_valid_o,
  output logic [FRAME_W-1:0] frame_data_o,
  output logic [BITS_W-1:0]  frame_bits_o
);
  localparam int IDLE_TICKS = IDLE_BITS * ONE_TICKS;
  localparam int CNT_W      = $clog2(IDLE_TICKS + 1);
  localparam logic [CNT_W-1:0] TIMEOUT = CNT_W'(ONE_TICKS + TOL_TICKS);

  logic             rise;
  logic [CNT_W-1:0] cnt;
  sym_e             sym;
  logic             timeout;

  ppd_interval_timer #(.CNT_W(CNT_W), .IDLE_TICKS(IDLE_TICKS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .env_i  (env_i),
    .tick_i (tick_i),
    .rise_o (rise),
    .cnt_o  (cnt)
  );

  ppd_classifier #(
    .CNT_W(CNT_W), .ONE_TICKS(ONE_TICKS), .ZERO_TICKS(ZERO_TICKS), .TOL_TICKS(TOL_TICKS)
  ) u_class (
    .cnt_i (cnt),
    .sym_o (sym)
  );

  assign timeout = (cnt >= TIMEOUT);

  ppd_frame_asm #(.FRAME_W(FRAME_W), .MIN_BITS(MIN_BITS), .BITS_W(BITS_W)) u_asm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .sym_i     (sym),
    .timeout_i (timeout),
    .valid_o   (frame_valid_o),
    .data_o    (frame_data_o),
    .bits_o    (frame_bits_o)
  );
endmodule

// File: tb/pulse_pause_rx_tb.sv
`timescale 1ns/1ps
module pulse_pause_rx_tb;
  localparam int CLK_NS = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        env_i = 1'b1;
  logic        tick_i = 1'b1;
  logic        frame_valid_o;
  logic [31:0] frame_data_o;
  logic [5:0]  frame_bits_o;

  int          n_checks = 0;
  int          n_fail = 0;
  int          n_strobe = 0;
  logic [31:0] cap_data;
  logic [5:0]  cap_bits;
  logic        prev_v = 1'b0;
  bit          half = 1'b0;
  bit          done = 1'b0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  pulse_pause_rx u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .env_i(env_i), .tick_i(tick_i),
    .frame_valid_o(frame_valid_o), .frame_data_o(frame_data_o), .frame_bits_o(frame_bits_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk_i) tick_i = half ? ~tick_i : 1'b1;

  // strobe monitor: one-cycle pulse, outputs cleared afterwards (R8)
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (prev_v)
        check(!frame_valid_o && frame_data_o == 0 && frame_bits_o == 0, "R8",
              "after strobe", {frame_valid_o, frame_bits_o, frame_data_o}, 0);
      if (frame_valid_o) begin
        n_strobe++;
        cap_data = frame_data_o;
        cap_bits = frame_bits_o;
      end
      prev_v = frame_valid_o;
    end
  end

  // next rising edge n clocks after the previous one
  task automatic rise_after(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      env_i = (i == n - 1) ? 1'b1 : ((i >= n - 11) ? 1'b0 : 1'b1);
    end
  endtask

  task automatic send(input logic [63:0] pat, input int n, input int one_gap, input int zero_gap);
    rise_after(300);
    for (int i = 0; i < n; i++) rise_after(pat[i] ? one_gap : zero_gap);
  endtask

  task automatic expect_frame(input int base, input logic [31:0] d, input int b, input string req);
    for (int i = 0; i < 600 && n_strobe == base; i++) begin
      @(negedge clk_i); #1;
    end
    check(n_strobe == base + 1, req, "strobe count", n_strobe - base, 1);
    check(cap_data == d, req, "frame data", cap_data, d);
    check(cap_bits == 6'(b), req, "bit count", cap_bits, b);
  endtask

  task automatic expect_none(input int base, input int cycles, input string req);
    repeat (cycles) @(negedge clk_i);
    #1;
    check(n_strobe == base, req, "no strobe", n_strobe - base, 0);
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk_i);
    check(!frame_valid_o && frame_data_o == 0 && frame_bits_o == 0, "R10", "reset outputs",
          {frame_valid_o, frame_bits_o, frame_data_o}, 0);
    rst_ni = 1'b1;
    rise_after(60); // first edge after reset: timing start only
    expect_none(0, 300, "R10");
  endtask

  task automatic t_mixed;
    int base = n_strobe;
    send(64'hB4, 8, 120, 60);
    expect_frame(base, 32'hB4, 8, "R2 R3 R4 R6");
  endtask

  task automatic t_window;
    int base = n_strobe;
    rise_after(300);
    rise_after(101); rise_after(139); rise_after(41); rise_after(79); rise_after(101);
    expect_frame(base, 32'h13, 5, "R2 R3 window edges");
  endtask

  task automatic t_reject(input int gap, input string req);
    int base = n_strobe;
    send(64'h1F, 5, 120, 60);
    rise_after(gap);
    @(negedge clk_i); #1;
    check(n_strobe == base + 1, req, "immediate close", n_strobe - base, 1);
    check(cap_data == 32'h1F && cap_bits == 6'd5, req, "closed frame", cap_data, 32'h1F);
    expect_none(base + 1, 300, req);
  endtask

  task automatic t_split;
    int base = n_strobe;
    send(64'h2D, 6, 120, 60);
    rise_after(90);
    @(negedge clk_i); #1;
    check(n_strobe == base + 1 && cap_data == 32'h2D, "R5", "first part", cap_data, 32'h2D);
    for (int i = 0; i < 5; i++) rise_after(i < 3 ? 120 : 60);
    expect_frame(base + 1, 32'h07, 5, "R5 new frame");
  endtask

  task automatic t_runt;
    int base = n_strobe;
    send(64'h0B, 4, 120, 60);
    expect_none(base, 400, "R7 four bits");
    send(64'h15, 5, 120, 60);
    expect_frame(base, 32'h15, 5, "R7 five bits");
  endtask

  task automatic t_overflow;
    int base = n_strobe;
    send(64'h2_9C3A_5F17, 34, 120, 60);
    expect_frame(base, 32'h9C3A_5F17, 32, "R4 saturation");
  endtask

  task automatic t_half_tick;
    int base = n_strobe;
    half = 1'b1;
    send(64'hA6, 8, 240, 120);
    expect_frame(base, 32'hA6, 8, "R1 tick gating");
    half = 1'b0;
  endtask

  task automatic t_idle;
    int base = n_strobe;
    expect_none(base, 3000, "R9 idle");
    send(64'h5A, 7, 120, 60);
    expect_frame(base, 32'h5A, 7, "R9 after idle");
  endtask

  initial begin
    #(CLK_NS * 190000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_mixed();
    t_window();
    t_reject(100, "R2 low bound 100");
    t_reject(80, "R3 high bound 80");
    t_reject(40, "R3 low bound 40");
    t_split();
    t_runt();
    t_overflow();
    t_half_tick();
    t_idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule